// File: doc/BRIEF.md
# Banked Control Register File with Masked Writes

This block holds the system-control registers of a small multithreaded core. Software reaches a register through a 5-bit register number and a 3-bit select, which together form an 8-bit slot address. Each implemented slot is either shared by the whole processor, banked per thread (the requesting thread id picks the bank), or banked per virtual processing element (the VPE field of the requesting thread's binding register picks the bank). Reads are combinational. Every software write is merged through a fixed per-slot write mask, so read-only fields keep their value.

Reset loads fixed values, including identification and configuration words taken from module parameters. A write to an implemented slot arms a one-cycle-deferred re-evaluation of which threads may run. Writes that arrive while that evaluation is armed are folded into it and do not arm another. The evaluation drives one run-enable bit per thread from that thread's halt and activation bits.

Top module: `cregs_file`

## Requirements
- R1: After reset the shared and VPE slots read: slot 0 = 0; slot 2 (machine config, read-only) = bit 15 set, bits [11:8] = NVPE-1, bits [7:0] = NTHR-1 (0x00008103 for 4 threads, 2 VPEs); slot 8 = 63; slot 104 = 0; slot 120 = ID_WORD; slot 128 = CFG0_INIT with bit 31 forced to 1; slot 129 = CFG1_INIT; per VPE v, slot 10 = 0x00000002 and slot 121 = 0x80000000 with CPU_NUM+v in bits [9:0].
- R2: After reset, per thread t: slot 96 = 0x00400004 (bits 22 and 2), slot 18 = t in bits [28:21], slot 20 = 0; slot 17 = 0x00008000 (activated, bit 15) for thread 0 and 0x00010000 (allocatable, bit 16) for every other thread.
- R3: The slot address is register number times 8 plus select. Slots other than 0, 2, 8, 10, 17, 18, 20, 96, 104, 120, 121, 128 and 129 read as zero, ignore writes and arm no re-evaluation.
- R4: A write stores (wdata AND mask) OR (old AND NOT mask). Masks: slot 0 0x7FFFFFFF, slot 10 0x000000FD, slot 17 0x000180FF, slot 18 0x00000001, slot 20 0x00000001, slot 96 0xFF78FF17, slot 104 0x08C00300, slot 121 0x3FFFF000, slot 128 0x7FFF0007.
- R5: Slots 2, 8, 120 and 129 have mask zero and keep their reset value under any write.
- R6: Slots 17, 18, 20 and 96 are banked per thread: an access uses the bank of the requesting thread, and a write by one thread leaves the other threads' copies unchanged.
- R7: Slots 10 and 121 are banked per VPE: the bank is bit 0 of the requesting thread's slot 18, so two threads bound to different VPEs see separate copies.
- R8: The re-evaluation flag is 1 in the cycle after a write to an implemented slot if it was 0 in the write cycle; it is never 1 in two consecutive cycles, and a write made while it is 1 does not set it again.
- R9: At the clock edge that ends a cycle with the flag set, run_en[t] becomes 1 exactly when slot 20 bit 0 of thread t is 0 and slot 17 bit 15 of thread t is 1, using register values that include any write in that same cycle; after reset run_en = thread 0 only.
- R10: run_en does not change at any edge that ends a cycle in which the flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_tid | input | TW | Requesting thread id |
| acc_num | input | 5 | Register number |
| acc_sel | input | 3 | Register select |
| wr_en | input | 1 | Write strobe for the addressed slot |
| wdata | input | 32 | Write data, merged through the slot mask |
| rdata | output | 32 | Combinational read of the addressed slot |
| reeval_pend | output | 1 | Deferred run-state evaluation armed |
| run_en | output | NTHR | Per-thread permission to run |

## Verification
Every cycle the checker confirms that the re-evaluation flag never stays high for two cycles and only rises after a write, that run_en moves only at edges ending a flagged cycle, that unimplemented slots read zero and that the VPE bank index stays in range. The values themselves (reset contents, mask merges, bank isolation between threads and VPEs, and the run decision folding in a write made during the flagged cycle) are shown only by the bench, which keeps its own copy of every slot and compares each read and each run_en bit against it under directed and random traffic.

// File: rtl/cregs_pkg.sv
package cregs_pkg;

    typedef logic [31:0] word_t;

    typedef enum logic [1:0] {
        BK_NONE   = 2'd0,
        BK_SHARED = 2'd1,
        BK_THREAD = 2'd2,
        BK_VPE    = 2'd3
    } bank_kind_e;

    typedef struct packed {
        bank_kind_e  kind;
        logic [2:0]  idx;
        word_t       mask;
    } slot_t;

    // storage counts per bank kind
    localparam int NSH = 7;
    localparam int NPT = 4;
    localparam int NPV = 2;

    // shared storage indices
    localparam logic [2:0] SH_INDEX  = 3'd0;
    localparam logic [2:0] SH_RAND   = 3'd1;
    localparam logic [2:0] SH_MPCONF = 3'd2;
    localparam logic [2:0] SH_CAUSE  = 3'd3;
    localparam logic [2:0] SH_IDENT  = 3'd4;
    localparam logic [2:0] SH_CFG0   = 3'd5;
    localparam logic [2:0] SH_CFG1   = 3'd6;

    // per-thread storage indices
    localparam logic [2:0] PT_PSTAT = 3'd0;
    localparam logic [2:0] PT_TSTAT = 3'd1;
    localparam logic [2:0] PT_BIND  = 3'd2;
    localparam logic [2:0] PT_HALT  = 3'd3;

    // per-VPE storage indices
    localparam logic [2:0] PV_CONF = 3'd0;
    localparam logic [2:0] PV_BASE = 3'd1;

    // slot addresses: register number * 8 + select
    localparam logic [7:0] F_INDEX  = 8'd0;
    localparam logic [7:0] F_MPCONF = 8'd2;
    localparam logic [7:0] F_RAND   = 8'd8;
    localparam logic [7:0] F_VCONF  = 8'd10;
    localparam logic [7:0] F_TSTAT  = 8'd17;
    localparam logic [7:0] F_BIND   = 8'd18;
    localparam logic [7:0] F_HALT   = 8'd20;
    localparam logic [7:0] F_PSTAT  = 8'd96;
    localparam logic [7:0] F_CAUSE  = 8'd104;
    localparam logic [7:0] F_IDENT  = 8'd120;
    localparam logic [7:0] F_VBASE  = 8'd121;
    localparam logic [7:0] F_CFG0   = 8'd128;
    localparam logic [7:0] F_CFG1   = 8'd129;

    // write masks
    localparam word_t M_INDEX = 32'h7FFF_FFFF;
    localparam word_t M_VCONF = 32'h0000_00FD;
    localparam word_t M_TSTAT = 32'h0001_80FF;
    localparam word_t M_HALT  = 32'h0000_0001;
    localparam word_t M_PSTAT = 32'hFF78_FF17;
    localparam word_t M_CAUSE = 32'h08C0_0300;
    localparam word_t M_VBASE = 32'h3FFF_F000;
    localparam word_t M_CFG0  = 32'h7FFF_0007;
    localparam word_t M_NONE  = 32'h0000_0000;

    // field positions
    localparam int TSTAT_ACT   = 15;
    localparam int TSTAT_ALLOC = 16;
    localparam int HALT_BIT    = 0;
    localparam int BIND_TC_LSB = 21;
    localparam int PSTAT_ERR   = 2;
    localparam int PSTAT_BOOT  = 22;
    localparam int MP_TCA      = 15;
    localparam int MP_NVPE_LSB = 8;
    localparam int VCONF_MVP   = 1;

endpackage

// File: rtl/cregs_decode.sv
module cregs_decode
    import cregs_pkg::*;
#(
    parameter word_t BIND_MASK = 32'h0000_0001
) (
    input  logic [4:0] num,
    input  logic [2:0] sel,
    output slot_t      slot
);
    logic [7:0] flat;
    assign flat = {num, sel};

    always_comb begin
        slot = '{kind: BK_NONE, idx: 3'd0, mask: M_NONE};
        case (flat)
            F_INDEX:  slot = '{kind: BK_SHARED, idx: SH_INDEX,  mask: M_INDEX};
            F_MPCONF: slot = '{kind: BK_SHARED, idx: SH_MPCONF, mask: M_NONE};
            F_RAND:   slot = '{kind: BK_SHARED, idx: SH_RAND,   mask: M_NONE};
            F_CAUSE:  slot = '{kind: BK_SHARED, idx: SH_CAUSE,  mask: M_CAUSE};
            F_IDENT:  slot = '{kind: BK_SHARED, idx: SH_IDENT,  mask: M_NONE};
            F_CFG0:   slot = '{kind: BK_SHARED, idx: SH_CFG0,   mask: M_CFG0};
            F_CFG1:   slot = '{kind: BK_SHARED, idx: SH_CFG1,   mask: M_NONE};
            F_PSTAT:  slot = '{kind: BK_THREAD, idx: PT_PSTAT,  mask: M_PSTAT};
            F_TSTAT:  slot = '{kind: BK_THREAD, idx: PT_TSTAT,  mask: M_TSTAT};
            F_BIND:   slot = '{kind: BK_THREAD, idx: PT_BIND,   mask: BIND_MASK};
            F_HALT:   slot = '{kind: BK_THREAD, idx: PT_HALT,   mask: M_HALT};
            F_VCONF:  slot = '{kind: BK_VPE,    idx: PV_CONF,   mask: M_VCONF};
            F_VBASE:  slot = '{kind: BK_VPE,    idx: PV_BASE,   mask: M_VBASE};
            default:  ;
        endcase
    end
endmodule

// File: rtl/cregs_bank_sel.sv
module cregs_bank_sel #(
    parameter int NTHR = 4,
    parameter int NVPE = 2,
    parameter int TW   = 2,
    parameter int VW   = 1
) (
    input  logic [TW-1:0]            tid,
    input  logic [NTHR-1:0][VW-1:0]  bind_vpe,
    output logic [TW-1:0]            thr_idx,
    output logic [VW-1:0]            vpe_idx
);
    // out-of-range thread ids fall back to bank 0
    assign thr_idx = (32'(tid) < NTHR) ? tid : '0;

    generate
        if (NVPE > 1) begin : g_multi_vpe
            assign vpe_idx = bind_vpe[thr_idx];
        end else begin : g_single_vpe
            logic unused_bind;
            assign unused_bind = ^bind_vpe;
            assign vpe_idx     = '0;
        end
    endgenerate
endmodule

// File: rtl/cregs_run_eval.sv
module cregs_run_eval #(
    parameter int NTHR = 4
) (
    input  logic [NTHR-1:0] active,
    input  logic [NTHR-1:0] halted,
    output logic [NTHR-1:0] run
);
    generate
        for (genvar t = 0; t < NTHR; t++) begin : g_thr
            assign run[t] = active[t] & ~halted[t];
        end
    endgenerate
endmodule

// File: rtl/cregs_file.sv
module cregs_file
    import cregs_pkg::*;
#(
    parameter int          NTHR      = 4,
    parameter int          NVPE      = 2,
    parameter logic [31:0] ID_WORD   = 32'h00A5_1234,
    parameter logic [31:0] CFG0_INIT = 32'h0000_0483,
    parameter logic [31:0] CFG1_INIT = 32'h1E19_0C8A,
    parameter logic [9:0]  CPU_NUM   = 10'd3,
    localparam int         TW        = (NTHR > 1) ? $clog2(NTHR) : 1,
    localparam int         VW        = (NVPE > 1) ? $clog2(NVPE) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TW-1:0]   acc_tid,
    input  logic [4:0]      acc_num,
    input  logic [2:0]      acc_sel,
    input  logic            wr_en,
    input  logic [31:0]     wdata,
    output logic [31:0]     rdata,
    output logic            reeval_pend,
    output logic [NTHR-1:0] run_en
);
    localparam word_t BIND_MASK = (NVPE > 1) ? word_t'((1 << $clog2(NVPE)) - 1) : '0;

    typedef struct packed {
        logic [NSH-1:0][31:0]            sh;
        logic [NTHR-1:0][NPT-1:0][31:0]  th;
        logic [NVPE-1:0][NPV-1:0][31:0]  vp;
        logic                            pend;
        logic [NTHR-1:0]                 run;
    } state_t;

    state_t st_q, st_d, nxt, rst_st;

    slot_t                 slot;
    logic [1:0]            slot_kind;
    logic [TW-1:0]         thr_idx;
    logic [VW-1:0]         vpe_idx;
    logic [NTHR-1:0][VW-1:0] bind_vpe;
    logic [NTHR-1:0]       act_v, halt_v, run_next;
    word_t                 cur, merged;
    logic                  wr_hit;

    cregs_decode #(.BIND_MASK(BIND_MASK)) u_dec (
        .num  (acc_num),
        .sel  (acc_sel),
        .slot (slot)
    );

    assign slot_kind = slot.kind;

    generate
        for (genvar t = 0; t < NTHR; t++) begin : g_bind
            assign bind_vpe[t] = st_q.th[t][PT_BIND][VW-1:0];
            assign act_v[t]    = nxt.th[t][PT_TSTAT][TSTAT_ACT];
            assign halt_v[t]   = nxt.th[t][PT_HALT][HALT_BIT];
        end
    endgenerate

    cregs_bank_sel #(.NTHR(NTHR), .NVPE(NVPE), .TW(TW), .VW(VW)) u_bsel (
        .tid      (acc_tid),
        .bind_vpe (bind_vpe),
        .thr_idx  (thr_idx),
        .vpe_idx  (vpe_idx)
    );

    cregs_run_eval #(.NTHR(NTHR)) u_eval (
        .active (act_v),
        .halted (halt_v),
        .run    (run_next)
    );

    // reset image
    always_comb begin
        rst_st = '0;
        rst_st.sh[SH_RAND]   = 32'd63;
        rst_st.sh[SH_MPCONF] = (32'd1 << MP_TCA)
                             | (32'(NVPE - 1) << MP_NVPE_LSB)
                             | 32'(NTHR - 1);
        rst_st.sh[SH_IDENT]  = ID_WORD;
        rst_st.sh[SH_CFG0]   = CFG0_INIT | 32'h8000_0000;
        rst_st.sh[SH_CFG1]   = CFG1_INIT;
        for (int t = 0; t < NTHR; t++) begin
            rst_st.th[t][PT_PSTAT] = (32'd1 << PSTAT_BOOT) | (32'd1 << PSTAT_ERR);
            rst_st.th[t][PT_TSTAT] = (t == 0) ? (32'd1 << TSTAT_ACT) : (32'd1 << TSTAT_ALLOC);
            rst_st.th[t][PT_BIND]  = 32'(t) << BIND_TC_LSB;
            rst_st.th[t][PT_HALT]  = '0;
        end
        for (int v = 0; v < NVPE; v++) begin
            rst_st.vp[v][PV_CONF] = 32'd1 << VCONF_MVP;
            rst_st.vp[v][PV_BASE] = 32'h8000_0000 | {22'd0, CPU_NUM + 10'(v)};
        end
        rst_st.run[0] = 1'b1;
    end

    // read selection
    always_comb begin
        case (slot.kind)
            BK_SHARED: cur = st_q.sh[slot.idx];
            BK_THREAD: cur = st_q.th[thr_idx][slot.idx[1:0]];
            BK_VPE:    cur = st_q.vp[vpe_idx][slot.idx[0]];
            default:   cur = '0;
        endcase
    end

    assign rdata  = cur;
    assign wr_hit = wr_en && (slot.kind != BK_NONE);
    assign merged = (wdata & slot.mask) | (cur & ~slot.mask);

    // register contents after this cycle's write, plus the flag
    always_comb begin
        nxt = st_q;
        if (wr_hit) begin
            case (slot.kind)
                BK_SHARED: nxt.sh[slot.idx]                = merged;
                BK_THREAD: nxt.th[thr_idx][slot.idx[1:0]]  = merged;
                BK_VPE:    nxt.vp[vpe_idx][slot.idx[0]]    = merged;
                default:   ;
            endcase
        end
        nxt.pend = wr_hit & ~st_q.pend;
    end

    // run state follows only at the end of an armed cycle
    always_comb begin
        st_d     = nxt;
        st_d.run = st_q.pend ? run_next : st_q.run;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= rst_st;
        else        st_q <= st_d;
    end

    assign reeval_pend = st_q.pend;
    assign run_en      = st_q.run;

endmodule

// File: rtl/cregs_file_chk.sv
module cregs_file_chk
    import cregs_pkg::*;
#(
    parameter int NTHR = 4,
    parameter int NVPE = 2,
    parameter int VW   = 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic            reeval_pend,
    input logic [NTHR-1:0] run_en,
    input logic [31:0]     rdata,
    input logic [1:0]      slot_kind,
    input logic [VW-1:0]   vpe_idx
);
    // R8: flag never held for two cycles
    a_r8_pend_single: assert property (@(posedge clk) disable iff (!rst_n)
        reeval_pend |=> !reeval_pend);

    // R8: flag only rises after a write made while it was low
    a_r8_pend_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reeval_pend) |-> $past(wr_en));

    // R10: run state holds across cycles without the flag
    a_r10_run_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !reeval_pend |=> $stable(run_en));

    // R3: unimplemented slot reads zero
    a_r3_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_kind == 2'(BK_NONE)) |-> (rdata == 32'd0));

    // R7: VPE bank index stays inside the bank count
    a_r7_vpe_range: assert property (@(posedge clk) disable iff (!rst_n)
        32'(vpe_idx) < NVPE);
endmodule

bind cregs_file cregs_file_chk #(.NTHR(NTHR), .NVPE(NVPE), .VW(VW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .reeval_pend (reeval_pend),
    .run_en      (run_en),
    .rdata       (rdata),
    .slot_kind   (slot_kind),
    .vpe_idx     (vpe_idx)
);

// File: tb/cregs_file_bench.sv
`timescale 1ns/1ps
module cregs_file_bench;

    localparam logic [31:0] ID_W   = 32'h00A5_1234;
    localparam logic [31:0] CFG0_W = 32'h0000_0483;
    localparam logic [31:0] CFG1_W = 32'h1E19_0C8A;
    localparam int          CPUN   = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  acc_tid = '0;
    logic [4:0]  acc_num = '0;
    logic [2:0]  acc_sel = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        reeval_pend;
    logic [3:0]  run_en;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] sh_m [256];
    logic [31:0] th_m [4][256];
    logic [31:0] vp_m [2][256];
    logic        pend_m;
    logic [3:0]  run_m;

    always #2.5 clk = ~clk;

    cregs_file #(.NTHR(4), .NVPE(2), .ID_WORD(ID_W), .CFG0_INIT(CFG0_W),
                 .CFG1_INIT(CFG1_W), .CPU_NUM(10'(CPUN))) u_cregs_file (
        .clk(clk), .rst_n(rst_n), .acc_tid(acc_tid), .acc_num(acc_num),
        .acc_sel(acc_sel), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
        .reeval_pend(reeval_pend), .run_en(run_en)
    );

    // 0 none, 1 shared, 2 per thread, 3 per VPE
    function automatic int kind_of(int f);
        case (f)
            0, 2, 8, 104, 120, 128, 129: return 1;
            17, 18, 20, 96:              return 2;
            10, 121:                     return 3;
            default:                     return 0;
        endcase
    endfunction

    function automatic logic [31:0] mask_of(int f);
        case (f)
            0:   return 32'h7FFF_FFFF;
            10:  return 32'h0000_00FD;
            17:  return 32'h0001_80FF;
            18:  return 32'h0000_0001;
            20:  return 32'h0000_0001;
            96:  return 32'hFF78_FF17;
            104: return 32'h08C0_0300;
            121: return 32'h3FFF_F000;
            128: return 32'h7FFF_0007;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] model_read(int tid, int f);
        case (kind_of(f))
            1: return sh_m[f];
            2: return th_m[tid][f];
            3: return vp_m[int'(th_m[tid][18][0])][f];
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(int f);
        case (kind_of(f))
            1: return "R4";
            2: return "R6";
            3: return "R7";
            default: return "R3";
        endcase
    endfunction

    task automatic model_reset();
        for (int f = 0; f < 256; f++) begin
            sh_m[f] = '0;
            for (int t = 0; t < 4; t++) th_m[t][f] = '0;
            for (int v = 0; v < 2; v++) vp_m[v][f] = '0;
        end
        sh_m[2]   = 32'h0000_8103;
        sh_m[8]   = 32'd63;
        sh_m[120] = ID_W;
        sh_m[128] = CFG0_W | 32'h8000_0000;
        sh_m[129] = CFG1_W;
        for (int t = 0; t < 4; t++) begin
            th_m[t][96] = 32'h0040_0004;
            th_m[t][17] = (t == 0) ? 32'h0000_8000 : 32'h0001_0000;
            th_m[t][18] = 32'(t) << 21;
        end
        for (int v = 0; v < 2; v++) begin
            vp_m[v][10]  = 32'h0000_0002;
            vp_m[v][121] = 32'h8000_0000 | 32'(CPUN + v);
        end
        pend_m = 1'b0;
        run_m  = 4'b0001;
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // one access cycle: drive, compare everything, then advance the model
    task automatic step(int tid, int f, bit we, logic [31:0] wd, string tag);
        string t;
        int    k;
        logic [31:0] old;
        @(negedge clk);
        acc_tid = 2'(tid);
        acc_num = 5'(f >> 3);
        acc_sel = 3'(f & 7);
        wr_en   = we;
        wdata   = wd;
        #1;
        t = (tag == "") ? tag_of(f) : tag;
        check(t, rdata, model_read(tid, f));
        check("R8", 32'(reeval_pend), 32'(pend_m));
        check("R9", 32'(run_en), 32'(run_m));
        @(posedge clk);
        k = kind_of(f);
        if (we && k != 0) begin
            old = model_read(tid, f);
            old = (wd & mask_of(f)) | (old & ~mask_of(f));
            if (k == 1) sh_m[f] = old;
            else if (k == 2) th_m[tid][f] = old;
            else vp_m[int'(th_m[tid][18][0])][f] = old;
        end
        if (pend_m) begin
            for (int i = 0; i < 4; i++)
                run_m[i] = th_m[i][17][15] && !th_m[i][20][0];
        end
        pend_m = (we && k != 0) && !pend_m;
    endtask

    initial begin
        #500000;
        n_bad++;
        $display("FAIL R8 watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int slots [13] = '{0, 2, 8, 10, 17, 18, 20, 96, 104, 120, 121, 128, 129};
        void'($urandom(32'd24681));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: shared and VPE reset contents
        foreach (slots[i]) if (kind_of(slots[i]) != 2) step(0, slots[i], 0, 0, "R1");
        step(1, 10, 0, 0, "R1");
        step(1, 121, 0, 0, "R1");
        // R2: per-thread reset contents
        for (int t = 0; t < 4; t++) begin
            step(t, 96, 0, 0, "R2");
            step(t, 17, 0, 0, "R2");
            step(t, 18, 0, 0, "R2");
            step(t, 20, 0, 0, "R2");
        end

        // R5: read-only slots keep their value
        step(0, 120, 1, 32'hFFFF_FFFF, "R5");
        step(0, 129, 1, 32'hFFFF_FFFF, "R5");
        step(0, 2,   1, 32'h0, "R5");
        step(0, 8,   1, 32'h0, "R5");
        step(0, 120, 0, 0, "R5");
        step(0, 129, 0, 0, "R5");
        step(0, 2,   0, 0, "R5");
        step(0, 8,   0, 0, "R5");

        // R4: mask merge, all ones then all zeros
        step(0, 104, 1, 32'hFFFF_FFFF, "R4");
        step(0, 104, 0, 0, "R4");
        step(0, 128, 1, 32'h0, "R4");
        step(0, 128, 0, 0, "R4");
        step(2, 96,  1, 32'h0, "R4");
        step(2, 96,  0, 0, "R4");

        // R3: unimplemented slot, write ignored, no flag
        step(0, 7, 1, 32'hDEAD_BEEF, "R3");
        step(0, 7, 0, 0, "R3");
        step(0, 7, 0, 0, "R3");

        // R6: thread 2 changed slot 96 above; thread 1 still sees reset value
        step(1, 96, 0, 0, "R6");
        step(3, 17, 1, 32'h0000_00AA, "R6");
        step(0, 17, 0, 0, "R6");

        // R7: thread 1 moves to VPE 1 and rewrites its base
        step(1, 18, 1, 32'h0000_0001, "R7");
        step(1, 121, 1, 32'h1234_5000, "R7");
        step(0, 121, 0, 0, "R7");
        step(1, 121, 0, 0, "R7");

        // R9/R8: activate thread 1, then halt thread 0 inside the armed cycle
        step(1, 17, 1, 32'h0000_8000, "R9");
        step(0, 20, 1, 32'h0000_0001, "R8");
        step(0, 20, 0, 0, "R9");
        step(0, 20, 0, 0, "R10");
        // back-to-back writes re-arm on alternate cycles
        step(0, 20, 1, 32'h0, "R8");
        step(0, 20, 1, 32'h0, "R8");
        step(0, 20, 1, 32'h0, "R8");
        step(0, 0, 0, 0, "R10");
        step(0, 0, 0, 0, "R10");

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            int r, f;
            bit we;
            r  = int'($urandom_range(0, 15));
            f  = (r < 13) ? slots[r] : int'($urandom_range(0, 255));
            we = ($urandom_range(0, 2) != 0);
            step(int'($urandom_range(0, 3)), f, we, $urandom(), "");
        end
        step(0, 0, 0, 0, "");
        step(0, 0, 0, 0, "");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule